// File: doc/BRIEF.md
# Parallel Tile Render Dispatcher

The dispatcher takes a rectangular region of a frame (origin and size) and cuts it into a grid of NX by NY equal sub-rectangles. NX and NY are powers of two, and each sub-rectangle size comes from a right shift of the region size. One sequential pixel walker is started for each sub-rectangle, and all walkers run at the same time. Each walker has its own request/response memory port. For every pixel it visits, it either reads the pixel, applies a simple colour increment and writes the result back, or, in clear mode, writes a zero pixel without reading.

The block uses two frame buffers. The `read_sel` output names the bank that the walkers read from, and writes go to the other bank. The dispatcher tracks each walker's done flag. When every flag is set, it raises `frame_done` and inverts `read_sel`. `frame_done` stays high until the next accepted start. Arbitration between the walker ports is left to whatever sits outside the block.

Both directions of each memory port use valid/ready. A request, once valid, holds its fields until ready is seen. The memory may stall a walker for any length of time through `req_ready` or by delaying `rsp_valid`. A walker accepts a response only while it is waiting for one.

Top module: `tile_dispatch`

## Requirements
- R1: After reset `frame_done` is 0, `read_sel` is 0, and no walker drives `req_valid` or `rsp_ready`.
- R2: With sw = width >> log2(NX) and sh = height >> log2(NY), walker (i,j) sits at port slot k = j*NX + i. It covers x from org_x + i*sw to org_x + i*sw + sw - 1 inclusive, and y from org_y + j*sh to org_y + j*sh + sh - 1 inclusive.
- R3: A walker visits the points x_start + a*STEP and y_start + b*STEP inside its bounds. y is the outer loop and x is the inner loop, so the write addresses y*32+x on one port strictly increase. Each covered pixel is written exactly once per frame, and no other pixel is written.
- R4: In normal mode each pixel is read from bank `read_sel` (req_write=0) and written to the other bank (req_write=1). The pixel is 32 bits: [7:0] red, [15:8] green, [23:16] blue, [31:24] alpha. The written value is the read value with bits [23:0] incremented by 1 modulo 2^24, so red wraps into green and green wraps into blue. Alpha is unchanged.
- R5: When `clear` is 1 at the accepted start, every covered pixel is written with 0 and no read request is issued.
- R6: Each walker has at most one outstanding access. It issues a pixel's write only after that pixel's read response. A request that is held off by `req_ready`=0 keeps its valid and its fields. Normal mode issues exactly one read per covered pixel.
- R7: `start` is accepted only while no frame is running. A start during a frame is ignored. `frame_done` rises once all walkers are done, stays high until the next accepted start, and no request is valid while it is high.
- R8: `read_sel` inverts exactly when `frame_done` rises and is stable at all other times.
- R9: If sw or sh is 0, no walker makes any access, and the frame still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted when idle |
| org_x | input | CW | Region origin x |
| org_y | input | CW | Region origin y |
| width | input | CW | Region width |
| height | input | CW | Region height |
| clear | input | 1 | Clear mode for the frame being started |
| req_valid | output | NW | Per-walker request valid |
| req_ready | input | NW | Per-walker request ready |
| req_write | output | NW | 1 = write to the other bank, 0 = read from bank read_sel |
| req_x | output | NW*CW | Per-walker pixel x, slot k at [k*CW +: CW] |
| req_y | output | NW*CW | Per-walker pixel y |
| req_data | output | NW*PW | Per-walker write data |
| rsp_valid | input | NW | Per-walker read response valid |
| rsp_ready | output | NW | Per-walker response ready |
| rsp_data | input | NW*PW | Per-walker read data |
| frame_done | output | 1 | All walkers finished, held until next start |
| read_sel | output | 1 | Bank currently read |

## Verification
The assertions check on every cycle that a stalled request is held stable, that a walker never has a request and a response wait open together, that `frame_done` holds until a start, that no request is valid while it is high, and that `read_sel` moves only on completion. Only the bench's scenarios can show the sub-rectangle bounds, the stepping coverage and raster order, the colour increment, the absence of reads in clear mode, the treatment of a start sent mid-frame, and the zero-size case. The bench does this by comparing both banks against its own model after each frame.

// File: rtl/tile_pkg.sv
package tile_pkg;
  typedef enum logic [2:0] {W_IDLE, W_RD, W_WAIT, W_WR, W_DONE} walk_st_e;

  // colour stand-in: red +1, carry into green, then blue; alpha kept
  function automatic logic [31:0] next_pixel(input logic [31:0] p);
    logic [7:0] r, g, b;
    r = p[7:0] + 8'd1;
    g = (p[7:0] == 8'hFF) ? p[15:8] + 8'd1 : p[15:8];
    b = (p[7:0] == 8'hFF && p[15:8] == 8'hFF) ? p[23:16] + 8'd1 : p[23:16];
    return {p[31:24], b, g, r};
  endfunction
endpackage

// File: rtl/tile_bounds.sv
module tile_bounds #(
  parameter int CW  = 16,
  parameter int NXL = 1,
  parameter int NYL = 1,
  parameter int IX  = 0,
  parameter int IY  = 0
) (
  input  logic [CW-1:0] org_x,
  input  logic [CW-1:0] org_y,
  input  logic [CW-1:0] width,
  input  logic [CW-1:0] height,
  output logic [CW-1:0] x_lo,
  output logic [CW-1:0] x_hi,
  output logic [CW-1:0] y_lo,
  output logic [CW-1:0] y_hi,
  output logic          empty
);
  logic [CW-1:0] sw, sh;
  assign sw    = width  >> NXL;
  assign sh    = height >> NYL;
  assign x_lo  = org_x + CW'(IX) * sw;
  assign y_lo  = org_y + CW'(IY) * sh;
  assign x_hi  = x_lo + sw - CW'(1);
  assign y_hi  = y_lo + sh - CW'(1);
  assign empty = (sw == '0) || (sh == '0);
endmodule

// File: rtl/tile_walker.sv
module tile_walker
  import tile_pkg::*;
#(
  parameter int CW   = 16,
  parameter int PW   = 32,
  parameter int STEP = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          clear_in,
  input  logic [CW-1:0] x_lo,
  input  logic [CW-1:0] x_hi,
  input  logic [CW-1:0] y_lo,
  input  logic [CW-1:0] y_hi,
  input  logic          empty,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [CW-1:0] req_x,
  output logic [CW-1:0] req_y,
  output logic [PW-1:0] req_data,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [PW-1:0] rsp_data,
  output logic          done
);
  walk_st_e      st;
  logic [CW-1:0] cx, cy, lx_lo, lx_hi, ly_hi;
  logic          clr;
  logic [PW-1:0] pix;
  logic [CW:0]   nx, ny;

  assign nx = {1'b0, cx} + (CW+1)'(STEP);
  assign ny = {1'b0, cy} + (CW+1)'(STEP);

  assign req_valid = (st == W_RD) || (st == W_WR);
  assign req_write = (st == W_WR);
  assign req_x     = cx;
  assign req_y     = cy;
  assign req_data  = clr ? '0 : pix;
  assign rsp_ready = (st == W_WAIT);
  assign done      = (st == W_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= W_IDLE; cx <= '0; cy <= '0; lx_lo <= '0; lx_hi <= '0;
      ly_hi <= '0; clr <= 1'b0; pix <= '0;
    end else if (go) begin
      lx_lo <= x_lo; lx_hi <= x_hi; ly_hi <= y_hi;
      cx <= x_lo; cy <= y_lo; clr <= clear_in;
      st <= empty ? W_DONE : (clear_in ? W_WR : W_RD);
    end else begin
      case (st)
        W_RD:   if (req_ready) st <= W_WAIT;
        W_WAIT: if (rsp_valid) begin
                  pix <= PW'(next_pixel(32'(rsp_data)));
                  st  <= W_WR;
                end
        W_WR:   if (req_ready) begin
                  if (nx > {1'b0, lx_hi}) begin
                    cx <= lx_lo;
                    if (ny > {1'b0, ly_hi}) st <= W_DONE;
                    else begin
                      cy <= ny[CW-1:0];
                      st <= clr ? W_WR : W_RD;
                    end
                  end else begin
                    cx <= nx[CW-1:0];
                    st <= clr ? W_WR : W_RD;
                  end
                end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tile_dispatch.sv
module tile_dispatch #(
  parameter int CW   = 16,
  parameter int PW   = 32,
  parameter int NXL  = 1,
  parameter int NYL  = 1,
  parameter int STEP = 1,
  localparam int NX  = 1 << NXL,
  localparam int NY  = 1 << NYL,
  localparam int NW  = NX * NY
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CW-1:0]    org_x,
  input  logic [CW-1:0]    org_y,
  input  logic [CW-1:0]    width,
  input  logic [CW-1:0]    height,
  input  logic             clear,
  output logic [NW-1:0]    req_valid,
  input  logic [NW-1:0]    req_ready,
  output logic [NW-1:0]    req_write,
  output logic [NW*CW-1:0] req_x,
  output logic [NW*CW-1:0] req_y,
  output logic [NW*PW-1:0] req_data,
  input  logic [NW-1:0]    rsp_valid,
  output logic [NW-1:0]    rsp_ready,
  input  logic [NW*PW-1:0] rsp_data,
  output logic             frame_done,
  output logic             read_sel
);
  logic          running, go;
  logic [NW-1:0] wdone;

  assign go = start && !running;

  for (genvar j = 0; j < NY; j++) begin : g_row
    for (genvar i = 0; i < NX; i++) begin : g_col
      localparam int K = j * NX + i;
      logic [CW-1:0] xl, xh, yl, yh;
      logic          emp;
      tile_bounds #(.CW(CW), .NXL(NXL), .NYL(NYL), .IX(i), .IY(j)) u_bnd (
        .org_x(org_x), .org_y(org_y), .width(width), .height(height),
        .x_lo(xl), .x_hi(xh), .y_lo(yl), .y_hi(yh), .empty(emp));
      tile_walker #(.CW(CW), .PW(PW), .STEP(STEP)) u_walk (
        .clk(clk), .rst_n(rst_n), .go(go), .clear_in(clear),
        .x_lo(xl), .x_hi(xh), .y_lo(yl), .y_hi(yh), .empty(emp),
        .req_valid(req_valid[K]), .req_ready(req_ready[K]),
        .req_write(req_write[K]), .req_x(req_x[K*CW +: CW]),
        .req_y(req_y[K*CW +: CW]), .req_data(req_data[K*PW +: PW]),
        .rsp_valid(rsp_valid[K]), .rsp_ready(rsp_ready[K]),
        .rsp_data(rsp_data[K*PW +: PW]), .done(wdone[K]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0; frame_done <= 1'b0; read_sel <= 1'b0;
    end else if (go) begin
      running <= 1'b1; frame_done <= 1'b0;
    end else if (running && (&wdone)) begin
      running <= 1'b0; frame_done <= 1'b1; read_sel <= ~read_sel;
    end
  end
endmodule

// File: rtl/tile_dispatch_chk.sv
module tile_dispatch_chk #(
  parameter int NW = 4,
  parameter int CW = 16,
  parameter int PW = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [NW-1:0]    req_valid,
  input logic [NW-1:0]    req_ready,
  input logic [NW-1:0]    req_write,
  input logic [NW*CW-1:0] req_x,
  input logic [NW*CW-1:0] req_y,
  input logic [NW*PW-1:0] req_data,
  input logic [NW-1:0]    rsp_ready,
  input logic             frame_done,
  input logic             read_sel
);
  for (genvar k = 0; k < NW; k++) begin : g_w
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[k] && !req_ready[k] |=> req_valid[k] && $stable(req_write[k]) &&
      $stable(req_x[k*CW +: CW]) && $stable(req_y[k*CW +: CW]) &&
      $stable(req_data[k*PW +: PW])); // R6
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ready[k] |-> !req_valid[k]); // R6
  end
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !start |=> frame_done); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> req_valid == '0); // R7
  AST_SEL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_done) |-> read_sel != $past(read_sel)); // R8
  AST_SEL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(frame_done) |-> $stable(read_sel)); // R8
endmodule

bind tile_dispatch tile_dispatch_chk #(.NW(NW), .CW(CW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .req_valid(req_valid),
  .req_ready(req_ready), .req_write(req_write), .req_x(req_x), .req_y(req_y),
  .req_data(req_data), .rsp_ready(rsp_ready), .frame_done(frame_done),
  .read_sel(read_sel));

// File: tb/tile_dispatch_tb.sv
module tile_dispatch_tb;
  localparam int CW = 16, PW = 32, NXL = 1, NYL = 1, STEP = 2;
  localparam int NW = (1 << NXL) * (1 << NYL);

  logic clk = 0, rst_n = 0, start = 0, clear = 0;
  logic [CW-1:0] org_x = 0, org_y = 0, width = 0, height = 0;
  logic [NW-1:0] req_valid, req_ready = 0, req_write, rsp_valid = 0, rsp_ready;
  logic [NW*CW-1:0] req_x, req_y;
  logic [NW*PW-1:0] req_data, rsp_data = 0;
  logic frame_done, read_sel;

  always #10 clk = ~clk;

  tile_dispatch #(.CW(CW), .PW(PW), .NXL(NXL), .NYL(NYL), .STEP(STEP)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .org_x(org_x), .org_y(org_y),
    .width(width), .height(height), .clear(clear), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_x(req_x), .req_y(req_y),
    .req_data(req_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .frame_done(frame_done), .read_sel(read_sel));

  logic [31:0] mem [0:1][0:1023];
  logic [31:0] snap_src [0:1023];
  logic [31:0] snap_dst [0:1023];
  int wcnt [0:1023];
  int rdcnt, ordviol, nchk = 0, nfail = 0, cyc = 0;
  int last_wa [0:NW-1];
  logic [NW-1:0] pend = 0;
  logic [31:0] rdat [0:NW-1];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] bump(input logic [31:0] p);
    return {p[31:24], p[23:0] + 24'd1};
  endfunction

  function automatic bit covered1(input int p, input int o, input int s);
    int d;
    if (s == 0 || p < o) return 0;
    d = p - o;
    if (d / s >= 2) return 0;
    return ((d % s) % STEP) == 0;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
    for (int k = 0; k < NW; k++) begin
      int a;
      a = int'(req_y[k*CW +: CW]) * 32 + int'(req_x[k*CW +: CW]);
      if (req_valid[k] && req_ready[k]) begin
        if (req_write[k]) begin
          mem[~read_sel][a] = req_data[k*PW +: PW];
          wcnt[a]++;
          if (a <= last_wa[k]) ordviol++;
          last_wa[k] = a;
        end else begin
          pend[k] = 1; rdat[k] = mem[read_sel][a]; rdcnt++;
        end
      end
      if (rsp_valid[k] && rsp_ready[k]) pend[k] = 0;
    end
  end

  always @(negedge clk) begin
    for (int k = 0; k < NW; k++) begin
      req_ready[k] <= ($urandom % 4) != 0;
      rsp_valid[k] <= pend[k] && (($urandom % 3) != 0);
      rsp_data[k*PW +: PW] <= rdat[k];
    end
  end

  task automatic run_frame(input int ox, input int oy, input int w, input int h,
                           input bit clr, input bit busy_poke);
    bit old_sel;
    int bad, badc, ncov, sw, sh, waitc;
    old_sel = read_sel;
    for (int a = 0; a < 1024; a++) begin
      snap_src[a] = mem[old_sel][a]; snap_dst[a] = mem[~old_sel][a]; wcnt[a] = 0;
    end
    rdcnt = 0; ordviol = 0;
    for (int k = 0; k < NW; k++) last_wa[k] = -1;
    @(negedge clk);
    org_x = CW'(ox); org_y = CW'(oy); width = CW'(w); height = CW'(h); clear = clr;
    start = 1;
    @(negedge clk);
    start = 0;
    if (busy_poke) begin
      repeat (5) @(negedge clk);
      org_x = 0; org_y = 0; width = 30; height = 30; clear = ~clr; start = 1;
      @(negedge clk);
      start = 0;
    end
    waitc = 0;
    while (!frame_done && waitc < 20000) begin @(negedge clk); waitc++; end
    check(frame_done, "R7 frame_done", frame_done, 1);
    check(read_sel == ~old_sel, "R8 read_sel toggle", read_sel, ~old_sel);
    sw = w >> NXL; sh = h >> NYL;
    bad = 0; badc = 0; ncov = 0;
    for (int y = 0; y < 32; y++)
      for (int x = 0; x < 32; x++) begin
        int a; bit c; logic [31:0] e;
        a = y * 32 + x;
        c = covered1(x, ox, sw) && covered1(y, oy, sh);
        ncov += c;
        e = c ? (clr ? 32'd0 : bump(snap_src[a])) : snap_dst[a];
        if (mem[~old_sel][a] !== e) bad++;
        if (mem[old_sel][a] !== snap_src[a]) bad++;
        if (wcnt[a] != int'(c)) badc++;
      end
    check(bad == 0, clr ? "R5 cleared contents" : "R4 updated contents", bad, 0);
    check(badc == 0, "R3 one write per covered pixel", badc, 0);
    check(ordviol == 0, "R3 raster order per walker", ordviol, 0);
    if (clr) check(rdcnt == 0, "R5 no reads in clear", rdcnt, 0);
    else check(rdcnt == ncov, "R6 one read per pixel", rdcnt, ncov);
    if (sw == 0 || sh == 0) check(rdcnt == 0 && ncov == 0, "R9 empty no access", rdcnt, 0);
    else check(ncov > 0, "R2 sub-rectangles cover", ncov, 1);
    repeat (4) @(negedge clk);
    check(frame_done && req_valid == 0, "R7 done held", frame_done, 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 1024; a++) mem[b][a] = $urandom;
    mem[0][0] = 32'h11FFFFFF; mem[0][2] = 32'h2200FFFF; mem[0][4] = 32'h33FF00FF;
    repeat (3) @(negedge clk);
    check(frame_done == 0, "R1 reset done", frame_done, 0);
    check(read_sel == 0, "R1 reset sel", read_sel, 0);
    check(req_valid == 0 && rsp_ready == 0, "R1 reset quiet", req_valid, 0);
    rst_n = 1;
    @(negedge clk);
    run_frame(0, 0, 24, 24, 0, 0);   // full-ish, carry patterns at origin
    run_frame(3, 5, 13, 9, 0, 0);    // odd sizes, inclusive ends with stepping
    run_frame(2, 2, 20, 14, 1, 0);   // clear mode
    run_frame(4, 4, 1, 10, 0, 0);    // zero-width sub-rectangles
    run_frame(1, 1, 16, 16, 0, 1);   // start during a frame ignored
    for (int n = 0; n < 6; n++)
      run_frame($urandom % 8, $urandom % 8, $urandom % 25, $urandom % 25,
                ($urandom % 4) == 0, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule